// File: doc/BRIEF.md
# Scatter-Gather DMA Read Engine

This block moves data from host memory to the device in two phases. Software first places a list of descriptors in host memory. Each descriptor names one contiguous buffer. Software then tells the engine where the list lives and how many entries it has, and sets a start bit. The engine fetches the whole list with a single read request and keeps the entries in a local store. When the last list word arrives, it raises an interrupt.

In the second phase the engine walks the stored entries in order. It issues one read request per buffer and passes the returned words to an output stream. When the last buffer has been delivered, it raises a second interrupt. Both interrupt causes sit in a status register that clears when it is read.

A misaligned descriptor ends the transfer with an error flag. So does a bad list setting.

The request port carries a byte address and a length in 32-bit words. Returned words arrive on a valid/ready stream.

Top module: `sg_dma_reader`

## Requirements
- R1: After reset the engine is idle. The status register (offset 3) and the control register (offset 2) read zero, `irq` is low, and `req_valid` and `out_valid` are low.
- R2: Writing 1 to bit 0 of offset 2 while idle starts a transfer, provided the list settings are valid. The engine then makes exactly one request with the list address (offset 0) and a length of twice the entry count (offset 1, bits 4:0), in words. Each entry is two words: the buffer address first, then its byte length.
- R3: When the last list word is accepted, status bit 0 (list fetched) sets and `irq` goes high.
- R4: Reading offset 3 returns the status bits. The bits that were set are then cleared, so `irq` is low in the next cycle unless a new event sets a flag.
- R5: Entries are served in list order. Each buffer request carries the entry address and its byte length divided by four. The next request is made only after every word of the current buffer has been delivered.
- R6: During the buffer phase, `out_valid`/`out_data` follow the completion stream in the same cycle, and `cpl_ready` equals `out_ready`. Words are delivered in the order they return.
- R7: An entry with a byte length of zero is skipped, and no request is issued for it.
- R8: After the last word of the last buffer, status bit 1 (transfer done) sets and `irq` goes high.
- R9: An entry whose address or length is not a multiple of four stops the transfer. Status bit 2 (error) sets, no request is made for that entry or any later one, the engine returns to idle, and `irq` stays low.
- R10: Bit 0 of offset 2 reads 1 while a transfer runs. While busy, writes to offsets 0, 1 and 2 have no effect.
- R11: A start with an entry count of 0, a count above 16, or a list address that is not a multiple of four sets status bit 2 and makes no request.
- R12: Once `req_valid` is high, the request and its address and length hold until `req_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read-to-clear) |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Level interrupt: list fetched or transfer done |
| req_valid | output | 1 | Memory read request valid |
| req_ready | input | 1 | Memory read request accepted |
| req_addr | output | 32 | Request byte address |
| req_dwords | output | 30 | Request length in 32-bit words |
| cpl_valid | input | 1 | Returned data valid |
| cpl_ready | output | 1 | Returned data accepted |
| cpl_data | input | 32 | Returned data word |
| out_valid | output | 1 | Output stream valid |
| out_ready | input | 1 | Output stream ready |
| out_data | output | 32 | Output stream word |

## Verification
Each flag is set on the clock edge that accepts the final list word or the final buffer word, or that decodes a bad entry, so `irq` and status are due one edge after that handshake. The stream outputs carry zero cycles of latency. The bench therefore drives inputs on the falling edge and samples every handshake 1 ns before the next rising edge, when the inputs and the combinational outputs are settled. A status read is clocked at the edge that ends the read strobe. `irq` is therefore checked after the following falling edge, which is one full edge after that read.

// File: rtl/sg_dma_reader.sv
module sg_dma_reader #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int MAX_DESC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [DW-3:0] req_dwords,
  input  logic          cpl_valid,
  output logic          cpl_ready,
  input  logic [DW-1:0] cpl_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  localparam int CW = $clog2(MAX_DESC + 1);
  localparam int WI = $clog2(2 * MAX_DESC);
  localparam int LW = DW - 2;

  typedef enum logic [2:0] {S_IDLE, S_LREQ, S_LRCV, S_DCHK, S_DREQ, S_DRCV} st_t;

  st_t            st;
  logic [AW-1:0]  cfg_addr;
  logic [CW-1:0]  cfg_cnt;
  logic           f_list, f_done, f_err;
  logic [CW:0]    wcnt;
  logic [CW-1:0]  idx;
  logic [LW-1:0]  remain;
  logic [DW-1:0]  dmem [2*MAX_DESC];

  logic busy, wr_ok, go, cfg_bad, cpl_hs, rd_stat, last_word;
  logic set_list, set_done, set_err, bad_ent;
  logic [CW:0]    ent0, ent1, list_words;
  logic [DW-1:0]  d_addr_w, d_len_w;

  assign busy       = st != S_IDLE;
  assign wr_ok      = reg_wr && !busy;
  assign go         = wr_ok && reg_addr == 2'd2 && reg_wdata[0];
  assign cfg_bad    = cfg_cnt == '0 || cfg_cnt > CW'(MAX_DESC) || cfg_addr[1:0] != 2'b00;
  assign cpl_hs     = cpl_valid && cpl_ready;
  assign rd_stat    = reg_rd && reg_addr == 2'd3;
  assign list_words = {cfg_cnt, 1'b0};
  assign last_word  = (wcnt + (CW+1)'(1)) == list_words;

  assign ent0     = {idx, 1'b0};
  assign ent1     = {idx, 1'b1};
  assign d_addr_w = dmem[ent0[WI-1:0]];
  assign d_len_w  = dmem[ent1[WI-1:0]];
  assign bad_ent  = d_addr_w[1:0] != 2'b00 || d_len_w[1:0] != 2'b00;

  assign set_list = st == S_LRCV && cpl_hs && last_word;
  assign set_done = st == S_DCHK && idx == cfg_cnt;
  assign set_err  = (go && cfg_bad) || (st == S_DCHK && idx != cfg_cnt && bad_ent);

  assign req_valid  = st == S_LREQ || st == S_DREQ;
  assign req_addr   = st == S_LREQ ? cfg_addr : d_addr_w[AW-1:0];
  assign req_dwords = st == S_LREQ ? LW'(list_words) : d_len_w[DW-1:2];
  assign cpl_ready  = st == S_LRCV || (st == S_DRCV && out_ready);
  assign out_valid  = st == S_DRCV && cpl_valid;
  assign out_data   = cpl_data;
  assign irq        = f_list || f_done;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = 32'(cfg_addr);
      2'd1:    reg_rdata = 32'(cfg_cnt);
      2'd2:    reg_rdata = {31'b0, busy};
      default: reg_rdata = {29'b0, f_err, f_done, f_list};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_addr <= '0;
      cfg_cnt  <= '0;
      f_list   <= 1'b0;
      f_done   <= 1'b0;
      f_err    <= 1'b0;
    end else begin
      if (wr_ok && reg_addr == 2'd0) cfg_addr <= reg_wdata[AW-1:0];
      if (wr_ok && reg_addr == 2'd1) cfg_cnt  <= reg_wdata[CW-1:0];
      f_list <= (f_list && !rd_stat) || set_list;
      f_done <= (f_done && !rd_stat) || set_done;
      f_err  <= (f_err  && !rd_stat) || set_err;
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_LRCV && cpl_hs) dmem[wcnt[WI-1:0]] <= cpl_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      wcnt   <= '0;
      idx    <= '0;
      remain <= '0;
    end else begin
      case (st)
        S_IDLE: if (go && !cfg_bad) begin
          st   <= S_LREQ;
          wcnt <= '0;
        end
        S_LREQ: if (req_ready) st <= S_LRCV;
        S_LRCV: if (cpl_hs) begin
          wcnt <= wcnt + (CW+1)'(1);
          if (last_word) begin
            st  <= S_DCHK;
            idx <= '0;
          end
        end
        S_DCHK: begin
          if (idx == cfg_cnt || bad_ent)      st  <= S_IDLE;
          else if (d_len_w[DW-1:2] == '0)     idx <= idx + CW'(1);
          else                                st  <= S_DREQ;
        end
        S_DREQ: if (req_ready) begin
          st     <= S_DRCV;
          remain <= d_len_w[DW-1:2];
        end
        S_DRCV: if (cpl_hs) begin
          remain <= remain - LW'(1);
          if (remain == LW'(1)) begin
            idx <= idx + CW'(1);
            st  <= S_DCHK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_dwords));

  assert_no_empty_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_dwords != '0);

  assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr |=> $stable(cfg_addr) && $stable(cfg_cnt));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !busy |=> !irq);

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_err) |-> !busy && !req_valid);

  assert_stream_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cpl_ready == out_ready);
endmodule

// File: tb/sg_dma_reader_test.sv
module sg_dma_reader_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, reg_wr, reg_rd, irq, req_valid, req_ready;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, req_addr, cpl_data, out_data;
  logic [29:0] req_dwords;
  logic        cpl_valid, cpl_ready, out_valid, out_ready;

  sg_dma_reader uut (.*);

  typedef struct { logic [31:0] a; logic [29:0] n; string tag; } rq_t;
  logic [31:0] mem [logic [31:0]];
  rq_t         exp_rq [$];
  logic [31:0] exp_out [$];
  logic [31:0] cq [$];
  int vecs = 0, errs = 0, cyc = 0;
  bit gate = 0, slow = 0, hold_pend = 0;
  logic [31:0] h_a;
  logic [29:0] h_n;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    req_ready = 0; cpl_valid = 0; cpl_data = 0; out_ready = 0;
    forever begin
      @(negedge clk);
      cyc++;
      cpl_valid = cq.size() > 0;
      cpl_data  = cpl_valid ? cq[0] : 32'h0;
      req_ready = slow ? cyc[0] : 1'b1;
      out_ready = gate && (slow ? cyc[1] : 1'b1);
      #4;
      if (hold_pend)
        check(req_valid && req_addr == h_a && req_dwords == h_n, "R12 request held", {req_addr, 2'b0, req_dwords}, {h_a, 2'b0, h_n});
      hold_pend = req_valid && !req_ready;
      h_a = req_addr; h_n = req_dwords;
      if (cpl_valid && cpl_ready) void'(cq.pop_front());
      if (out_valid && out_ready) begin
        if (exp_out.size() == 0) check(0, "R6 unexpected word", out_data, 0);
        else begin
          logic [31:0] e;
          e = exp_out.pop_front();
          check(out_data == e, "R6 stream word", out_data, e);
        end
      end
      if (req_valid && req_ready) begin
        if (exp_rq.size() == 0) check(0, "R5 unexpected request", req_addr, 0);
        else begin
          rq_t r;
          r = exp_rq.pop_front();
          check(req_addr == r.a && req_dwords == r.n, r.tag, {req_addr, 2'b0, req_dwords}, {r.a, 2'b0, r.n});
          check(cq.size() == 0, "R5 previous buffer drained", cq.size(), 0);
          for (int i = 0; i < int'(req_dwords); i++) cq.push_back(mem[req_addr + 32'(4*i)]);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #4 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_irq(input string r);
    int n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    check(irq, r, irq, 1);
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int n = 0; n < 2000; n++) begin
      rd(2'd2, d);
      if (d[0] == 1'b0) return;
    end
    check(0, "R9 engine returned idle", 1, 0);
  endtask

  task automatic set_list(input logic [31:0] base, input int cnt);
    mem[base] = 0;
    exp_rq.push_back('{base, 30'(2*cnt), "R2 list request"});
  endtask

  task automatic add_desc(input logic [31:0] base, input int i, input logic [31:0] a,
                          input logic [31:0] len, input bit served);
    mem[base + 32'(8*i)]     = a;
    mem[base + 32'(8*i + 4)] = len;
    if (served && len != 0) begin
      exp_rq.push_back('{a, len[31:2], "R5 buffer request"});
      for (int j = 0; j < int'(len[31:2]); j++) begin
        logic [31:0] w;
        w = (a + 32'(4*j)) ^ 32'hA5C3_0000;
        mem[a + 32'(4*j)] = w;
        exp_out.push_back(w);
      end
    end
  endtask

  task automatic expect_status(input logic [31:0] exp, input string r);
    logic [31:0] d;
    rd(2'd3, d);
    check(d == exp, r, d, exp);
    #1 check(irq == 1'b0, "R4 irq low after read", irq, 0);
  endtask

  task automatic drained(input string r);
    check(exp_rq.size() == 0, {r, " requests consumed"}, exp_rq.size(), 0);
    check(exp_out.size() == 0, {r, " words delivered"}, exp_out.size(), 0);
  endtask

  initial begin
    #1_000_000;
    check(0, "watchdog", 1, 0);
    report();
  end

  initial begin
    logic [31:0] d;
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(irq == 0 && req_valid == 0 && out_valid == 0, "R1 outputs idle", {irq, req_valid, out_valid}, 0);
    rd(2'd3, d); check(d == 0, "R1 status zero", d, 0);
    rd(2'd2, d); check(d == 0, "R1 control zero", d, 0);

    // normal run, middle entry zero length (R7)
    set_list(32'h1000, 3);
    add_desc(32'h1000, 0, 32'h2000, 16, 1);
    add_desc(32'h1000, 1, 32'h3000, 0, 1);
    add_desc(32'h1000, 2, 32'h4000, 8, 1);
    gate = 0;
    wr(2'd0, 32'h1000); wr(2'd1, 3); wr(2'd2, 1);
    rd(2'd2, d); check(d == 1, "R10 busy bit", d, 1);
    wait_irq("R3 list irq");
    expect_status(32'h1, "R3 list flag");
    wr(2'd0, 32'h7770_0000); wr(2'd1, 5); wr(2'd2, 1);
    gate = 1;
    wait_irq("R8 done irq");
    expect_status(32'h2, "R8 done flag");
    rd(2'd0, d); check(d == 32'h1000, "R10 addr write ignored", d, 32'h1000);
    rd(2'd1, d); check(d == 3, "R10 count write ignored", d, 3);
    drained("R7");

    // slow handshakes, trailing zero entry
    slow = 1;
    set_list(32'h8000, 4);
    add_desc(32'h8000, 0, 32'h9000, 64, 1);
    add_desc(32'h8000, 1, 32'hA004, 4, 1);
    add_desc(32'h8000, 2, 32'hB000, 12, 1);
    add_desc(32'h8000, 3, 32'hC000, 0, 1);
    wr(2'd0, 32'h8000); wr(2'd1, 4); wr(2'd2, 1);
    wait_irq("R3 list irq slow");
    expect_status(32'h1, "R3 list flag slow");
    wait_irq("R8 done irq slow");
    expect_status(32'h2, "R8 done flag slow");
    drained("R12");
    slow = 0;

    // misaligned address in entry 1
    gate = 0;
    set_list(32'h1800, 3);
    add_desc(32'h1800, 0, 32'h2800, 8, 1);
    add_desc(32'h1800, 1, 32'h5002, 8, 0);
    add_desc(32'h1800, 2, 32'h6000, 8, 0);
    wr(2'd0, 32'h1800); wr(2'd1, 3); wr(2'd2, 1);
    wait_irq("R3 list irq abort");
    expect_status(32'h1, "R3 list flag abort");
    gate = 1;
    wait_idle();
    expect_status(32'h4, "R9 error flag address");
    drained("R9");

    // misaligned length in entry 0
    set_list(32'h1C00, 1);
    add_desc(32'h1C00, 0, 32'h2C00, 6, 0);
    wr(2'd0, 32'h1C00); wr(2'd1, 1); wr(2'd2, 1);
    wait_idle();
    expect_status(32'h5, "R9 error flag length");
    drained("R9 length");

    // bad list settings
    wr(2'd0, 32'h1000); wr(2'd1, 0); wr(2'd2, 1);
    expect_status(32'h4, "R11 zero count");
    wr(2'd1, 17); wr(2'd2, 1);
    expect_status(32'h4, "R11 count above max");
    wr(2'd0, 32'h1002); wr(2'd1, 1); wr(2'd2, 1);
    expect_status(32'h4, "R11 misaligned list");
    repeat (4) @(negedge clk);
    drained("R11");

    // full list of sixteen entries
    set_list(32'h4_0000, 16);
    for (int i = 0; i < 16; i++) add_desc(32'h4_0000, i, 32'h5_0000 + 32'(64*i), 4, 1);
    wr(2'd0, 32'h4_0000); wr(2'd1, 16); wr(2'd2, 1);
    wait_irq("R3 list irq max");
    d = 0;
    for (int n = 0; n < 2000 && uut.busy; n++) @(negedge clk);
    expect_status(32'h3, "R8 both flags max list");
    drained("R2 max");

    report();
  end
endmodule